// File: doc/BRIEF.md
# Socket status-change interrupt unit

This unit watches one removable-card socket and produces a single host interrupt. It samples two card-detect pins, two battery-detect pins and the card's own active-low request pin. Every pin passes through a synchroniser. A change on any of the four socket pins is recorded in a sticky flag, and each flag can be masked on its own. Software selects whether the card's request is read as a level or as a pulse. The host interrupt is a registered level formed from the unmasked flags and the request.

Software uses a small four-word register window. Address 0 returns the live synchronised pins. Address 1 returns the sticky flags and is cleared by writing ones. Address 2 holds the per-source enables. Address 3 holds the request mode and the power state. In partial power-down the unit keeps monitoring. In full power-down sampling and detection freeze and the interrupt is held low, but the registers stay accessible so software can wake the unit.

Top module: `card_irq_unit`

## Requirements
- R1: After a synchronous reset, host_irq is 0 and every register reads 0.
- R2: Address 0 reads the synchronised pins, with card_det_n[0] at bit 0, card_det_n[1] at bit 1, batt_det[0] at bit 2, batt_det[1] at bit 3 and card_req_n at bit 4. A pin is visible SYNC_STAGES cycles after it is sampled, and the field reads 0 until the synchroniser has filled.
- R3: A change on socket pin i (bit positions as in R2, i = 0..3) sets change flag i at address 1 on the cycle after it reaches the synchroniser output. Changes are ignored during the first SYNC_STAGES+1 running cycles after reset.
- R4: Writing a 1 to a bit of address 1 clears that flag, and writing 0 leaves it unchanged. When a new change and a clear of the same flag fall in the same cycle, the flag stays set.
- R5: Enable bit i at address 2 (1 = enabled) masks only the interrupt contribution of flag i. The flags are still set while their source is masked.
- R6: With control bit 0 at 0 (level mode), the request drives host_irq while the synchronised card_req_n is low, and the pending bit 4 of address 1 is never set.
- R7: With control bit 0 at 1 (pulse mode), a falling edge of the synchronised card_req_n sets pending bit 4 of address 1. The bit holds host_irq asserted until software writes a 1 to bit 4.
- R8: Control bits 2:1 select the power state: 00 is run and 01 is partial power-down, and both behave identically. 10 and 11 are full power-down, which forces host_irq to 0.
- R9: In full power-down the synchroniser, the live status and the change detection freeze, so no flag is set. A pin that changed during full power-down is flagged after the unit returns to run or partial.
- R10: host_irq is registered. It rises one cycle after an enabled flag or an active request appears, and it falls one cycle after the last one is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_det_n | input | N_DET | Asynchronous card-detect pins |
| batt_det | input | N_BVD | Asynchronous battery-detect pins |
| card_req_n | input | 1 | Asynchronous active-low card request |
| reg_addr | input | 2 | Register word address |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | N_DET+N_BVD+1 | Write data |
| reg_rdata | output | N_DET+N_BVD+1 | Read data for the address of the previous cycle |
| host_irq | output | 1 | Level interrupt to the host |

## Verification
On every cycle the assertions check four behaviours:
- the synchroniser holds still in full power-down;
- a change flag only falls through an explicit clear;
- a change wins over a clear arriving in the same cycle;
- the pending bit is captured on a falling request edge in pulse mode and never rises in level mode.

A further assertion checks that full power-down silences the interrupt.

Only the bench's scenarios can show the rest. These are the exact latency from a pin edge to a flag and to host_irq, the masking of individual sources, and the level/pulse switch. They also cover the report, after wake-up, of a card removed while the unit was fully off. A behavioural model compares host_irq and reg_rdata with the design on every cycle.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;
  localparam int REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] REG_LIVE   = 2'd0;
  localparam logic [REG_ADDR_W-1:0] REG_CHANGE = 2'd1;
  localparam logic [REG_ADDR_W-1:0] REG_ENABLE = 2'd2;
  localparam logic [REG_ADDR_W-1:0] REG_CTRL   = 2'd3;

  typedef enum logic [1:0] {
    PWR_RUN      = 2'd0,
    PWR_PARTIAL  = 2'd1,
    PWR_FULL     = 2'd2,
    PWR_FULL_ALT = 2'd3
  } pwr_mode_e;

  function automatic logic pwr_is_off(input pwr_mode_e m);
    return (m == PWR_FULL) || (m == PWR_FULL_ALT);
  endfunction
endpackage

// File: rtl/card_irq_sync.sv
module card_irq_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze_i,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else if (!freeze_i) begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

  // R9
  sync_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    freeze_i |=> $stable(sync_o));
endmodule

// File: rtl/card_irq_detect.sv
module card_irq_detect #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze_i,
  input  logic [WIDTH-1:0] sync_i,
  output logic             ready_o,
  output logic [WIDTH-1:0] chg_o
);
  localparam int WARM  = STAGES + 1;
  localparam int CNT_W = $clog2(WARM + 1);

  logic [WIDTH-1:0] prev_q;
  logic [CNT_W-1:0] warm_q;

  assign ready_o = (warm_q == CNT_W'(WARM));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      warm_q <= '0;
    end else if (!freeze_i) begin
      prev_q <= sync_i;
      if (!ready_o) begin
        warm_q <= warm_q + 1'b1;
      end
    end
  end

  assign chg_o = (ready_o && !freeze_i) ? (sync_i ^ prev_q) : '0;
endmodule

// File: rtl/card_irq_flags.sv
module card_irq_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & $past(flags_q & ~clr_i)) == $past(flags_q & ~clr_i)));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/card_irq_req.sv
module card_irq_req (
  input  logic clk,
  input  logic rst,
  input  logic pulse_mode_i,
  input  logic ready_i,
  input  logic req_sync_i,
  input  logic req_chg_i,
  input  logic clr_i,
  output logic pend_o,
  output logic active_o
);
  logic pend_q;
  logic fall;

  assign fall = req_chg_i && !req_sync_i;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= (pend_q && !clr_i) || (pulse_mode_i && fall);
  end

  assign pend_o   = pend_q;
  assign active_o = ready_i && (pulse_mode_i ? pend_q : !req_sync_i);

  // R7
  pulse_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_mode_i && fall) |=> pend_q);

  // R6
  level_no_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (!pulse_mode_i && !pend_q) |=> !pend_q);
endmodule

// File: rtl/card_irq_unit.sv
module card_irq_unit #(
  parameter int N_DET       = 2,
  parameter int N_BVD       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_DET-1:0]       card_det_n,
  input  logic [N_BVD-1:0]       batt_det,
  input  logic                   card_req_n,
  input  logic [1:0]             reg_addr,
  input  logic                   reg_wr,
  input  logic [N_DET+N_BVD:0]   reg_wdata,
  output logic [N_DET+N_BVD:0]   reg_rdata,
  output logic                   host_irq
);
  import card_irq_pkg::*;

  localparam int N_SRC = N_DET + N_BVD;
  localparam int REG_W = N_SRC + 1;

  logic [REG_W-1:0] pins;
  logic [REG_W-1:0] sync_v;
  logic [REG_W-1:0] chg_v;
  logic             ready;
  logic [N_SRC-1:0] flags;
  logic [N_SRC-1:0] clr_flags;
  logic             clr_pend;
  logic             pend;
  logic             req_active;
  logic [N_SRC-1:0] en_q;
  logic             pulse_q;
  pwr_mode_e        pwr_q;
  logic             off;
  logic             wr_change;

  assign pins = {card_req_n, batt_det, card_det_n};
  assign off  = pwr_is_off(pwr_q);

  card_irq_sync #(.WIDTH(REG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .freeze_i(off), .async_i(pins), .sync_o(sync_v)
  );

  card_irq_detect #(.WIDTH(REG_W), .STAGES(SYNC_STAGES)) u_detect (
    .clk(clk), .rst(rst), .freeze_i(off), .sync_i(sync_v),
    .ready_o(ready), .chg_o(chg_v)
  );

  assign wr_change = reg_wr && (reg_addr == REG_CHANGE);
  assign clr_flags = wr_change ? reg_wdata[N_SRC-1:0] : '0;
  assign clr_pend  = wr_change && reg_wdata[N_SRC];

  card_irq_flags #(.N(N_SRC)) u_flags (
    .clk(clk), .rst(rst), .set_i(chg_v[N_SRC-1:0]), .clr_i(clr_flags),
    .flags_o(flags)
  );

  card_irq_req u_req (
    .clk(clk), .rst(rst), .pulse_mode_i(pulse_q), .ready_i(ready),
    .req_sync_i(sync_v[N_SRC]), .req_chg_i(chg_v[N_SRC]), .clr_i(clr_pend),
    .pend_o(pend), .active_o(req_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      pulse_q <= 1'b0;
      pwr_q   <= PWR_RUN;
    end else if (reg_wr) begin
      if (reg_addr == REG_ENABLE) en_q <= reg_wdata[N_SRC-1:0];
      if (reg_addr == REG_CTRL) begin
        pulse_q <= reg_wdata[0];
        pwr_q   <= pwr_mode_e'(reg_wdata[2:1]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        REG_LIVE:   reg_rdata <= sync_v;
        REG_CHANGE: reg_rdata <= {pend, flags};
        REG_ENABLE: reg_rdata <= {1'b0, en_q};
        default:    reg_rdata <= REG_W'({pwr_q, pulse_q});
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_irq <= 1'b0;
    else     host_irq <= !off && ((|(flags & en_q)) || req_active);
  end

  // R8
  full_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    off |=> !host_irq);
endmodule

// File: tb/card_irq_unit_bench.sv
module card_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] card_det_n = 2'b11;
  logic [1:0] batt_det = 2'b11;
  logic       card_req_n = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [4:0] reg_wdata = '0;
  logic [4:0] reg_rdata;
  logic       host_irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  card_irq_unit u_card_irq_unit (
    .clk(clk), .rst(rst), .card_det_n(card_det_n), .batt_det(batt_det),
    .card_req_n(card_req_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_irq(host_irq)
  );

  // behavioural reference model
  logic [4:0] mq[$];
  logic [3:0] m_flags = '0;
  logic       m_pend = 0;
  logic [3:0] m_en = '0;
  logic [2:0] m_ctrl = '0;
  logic       m_irq = 0;
  logic [4:0] m_rdata = '0;
  logic [1:0] m_raddr = '0;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      m_flags = '0; m_pend = 0; m_en = '0; m_ctrl = '0;
      m_irq = 0; m_rdata = '0; m_raddr = '0;
    end else begin
      automatic int         sz    = mq.size();
      automatic logic [4:0] s2    = (sz >= 2) ? mq[1] : 5'd0;
      automatic logic [4:0] prv   = (sz >= 3) ? mq[2] : 5'd0;
      automatic logic       rdy   = (sz >= 3);
      automatic logic       full  = m_ctrl[2];
      automatic logic       pulse = m_ctrl[0];
      automatic logic [4:0] chg   = (!full && rdy) ? (s2 ^ prv) : 5'd0;
      automatic logic       ract  = rdy && (pulse ? m_pend : !s2[4]);
      automatic logic [4:0] clr   = (reg_wr && reg_addr == 2'd1) ? reg_wdata : 5'd0;
      m_raddr = reg_addr;
      case (reg_addr)
        2'd0: m_rdata = s2;
        2'd1: m_rdata = {m_pend, m_flags};
        2'd2: m_rdata = {1'b0, m_en};
        default: m_rdata = {2'b00, m_ctrl};
      endcase
      m_irq   = !full && ((|(m_flags & m_en)) || ract);
      m_flags = (m_flags & ~clr[3:0]) | chg[3:0];
      m_pend  = (m_pend && !clr[4]) || (pulse && chg[4] && !s2[4]);
      if (reg_wr && reg_addr == 2'd2) m_en = reg_wdata[3:0];
      if (reg_wr && reg_addr == 2'd3) m_ctrl = reg_wdata[2:0];
      if (!full) begin
        mq.push_front({card_req_n, batt_det, card_det_n});
        if (mq.size() > 3) void'(mq.pop_back());
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      chk("R10 host_irq vs model", {31'd0, host_irq}, {31'd0, m_irq});
      case (m_raddr)
        2'd0: chk("R2 live vs model", {27'd0, reg_rdata}, {27'd0, m_rdata});
        2'd1: chk("R3 change vs model", {27'd0, reg_rdata}, {27'd0, m_rdata});
        2'd2: chk("R5 enable vs model", {27'd0, reg_rdata}, {27'd0, m_rdata});
        default: chk("R8 ctrl vs model", {27'd0, reg_rdata}, {27'd0, m_rdata});
      endcase
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [4:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [4:0] exp);
    logic [4:0] v;
    rd(a, v);
    chk(tag, {27'd0, v}, {27'd0, exp});
  endtask

  task automatic report();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(6);
    chk("R1 irq after reset", {31'd0, host_irq}, 32'd0);
    rd_chk("R1 change reg after reset", 2'd1, 5'h00);
    rd_chk("R1 enable reg after reset", 2'd2, 5'h00);
    rd_chk("R1 ctrl reg after reset", 2'd3, 5'h00);
    rd_chk("R2 live idle pins", 2'd0, 5'h1F);

    card_det_n = 2'b00;
    wait_n(6);
    rd_chk("R3 insert flags", 2'd1, 5'h03);
    chk("R5 masked insert irq", {31'd0, host_irq}, 32'd0);
    rd_chk("R2 live inserted", 2'd0, 5'h1C);

    wr(2'd2, 5'h03);
    wait_n(2);
    chk("R5 enabled irq", {31'd0, host_irq}, 32'd1);
    wr(2'd1, 5'h01);
    wait_n(2);
    rd_chk("R4 partial clear", 2'd1, 5'h02);
    chk("R10 irq held by other flag", {31'd0, host_irq}, 32'd1);
    wr(2'd1, 5'h02);
    wait_n(2);
    chk("R10 irq after all cleared", {31'd0, host_irq}, 32'd0);

    batt_det = 2'b10;
    wait_n(6);
    rd_chk("R3 battery flag", 2'd1, 5'h04);
    chk("R5 battery masked", {31'd0, host_irq}, 32'd0);
    wr(2'd2, 5'h0F);
    wait_n(2);
    chk("R5 battery enabled", {31'd0, host_irq}, 32'd1);
    wr(2'd1, 5'h04);
    wait_n(2);
    chk("R4 battery cleared", {31'd0, host_irq}, 32'd0);

    batt_det = 2'b00;
    wait_n(2);
    wr(2'd1, 5'h08);
    rd_chk("R4 set wins over clear", 2'd1, 5'h08);
    wr(2'd1, 5'h08);
    wait_n(2);
    chk("R4 cleared after race", {31'd0, host_irq}, 32'd0);

    wr(2'd2, 5'h00);
    card_req_n = 1'b0;
    wait_n(4);
    chk("R6 level request irq", {31'd0, host_irq}, 32'd1);
    rd_chk("R2 live request low", 2'd0, 5'h00);
    card_req_n = 1'b1;
    wait_n(4);
    chk("R6 level request gone", {31'd0, host_irq}, 32'd0);
    rd_chk("R6 no pending in level mode", 2'd1, 5'h00);

    wr(2'd3, 5'h01);
    card_req_n = 1'b0;
    wait_n(1);
    card_req_n = 1'b1;
    wait_n(6);
    chk("R7 pulse held irq", {31'd0, host_irq}, 32'd1);
    rd_chk("R7 pending bit", 2'd1, 5'h10);
    wr(2'd1, 5'h10);
    wait_n(2);
    chk("R7 pending cleared", {31'd0, host_irq}, 32'd0);

    wr(2'd3, 5'h03);
    card_det_n = 2'b01;
    wait_n(6);
    rd_chk("R8 partial still flags", 2'd1, 5'h01);
    wr(2'd2, 5'h01);
    wait_n(2);
    chk("R8 partial irq", {31'd0, host_irq}, 32'd1);

    wr(2'd3, 5'h05);
    wait_n(2);
    chk("R8 full forces irq low", {31'd0, host_irq}, 32'd0);
    card_det_n = 2'b11;
    wait_n(6);
    rd_chk("R9 no flag while full", 2'd1, 5'h01);
    rd_chk("R9 live frozen", 2'd0, 5'h11);
    wr(2'd3, 5'h01);
    wait_n(6);
    rd_chk("R9 change reported after wake", 2'd1, 5'h03);
    chk("R9 irq after wake", {31'd0, host_irq}, 32'd1);

    wr(2'd3, 5'h07);
    wait_n(2);
    chk("R8 alternate full code", {31'd0, host_irq}, 32'd0);
    wait_n(2);
    report();
  end
endmodule